// File: doc/BRIEF.md
# Queued ADC Conversion Sequencer

This block runs lists of analog-to-digital conversions without processor involvement. Software loads a 64-entry table of command words through a write port. Each word selects a converter channel, a sample-time code and an amplifier bypass option, and can also ask the queue to pause. Two queues share the table. Queue 1 always begins at entry 0. Queue 2 begins at an entry that software chooses. A trigger starts a queue, and each queue ends when it reaches an entry whose channel field holds the end-of-queue code.

For each entry it runs, the sequencer sends one request to an external converter and waits for the matching done strobe. It then stores the 10-bit result at the same index of a 64-entry result table. Software reads any result through a combinational read port, in one of three 16-bit alignments. Each queue has its own trigger source, its own status code and its own overrun flag. Queue 1 is served ahead of queue 2 at every entry boundary.

Top module: `adcq_seq`

## Requirements
- R1: A write with `cmd_we` high stores `cmd_wdata[9:0]` at entry `cmd_addr`. The word fields are channel in bits [5:0], sample-time code in bits [7:6], bypass in bit 8 and pause in bit 9. Bits [15:10] are ignored.
- R2: When `qN_mode` is 0, queue N is started only by a one-cycle high pulse on `sw_go[N-1]`. When `qN_mode` is 1, queue N is started only by a rising edge on `ext_trig[N-1]`. The source that is not selected has no effect.
- R3: A trigger on an idle or complete queue starts it at its first entry: entry 0 for queue 1, entry `q2_start` for queue 2. The queue then runs the entries in ascending order. An entry whose channel field is 63 ends the queue without a conversion, and the queue status becomes complete.
- R4: For each entry it runs, the block pulses `conv_req` high for one cycle. At the same time it presents the channel, sample-time code and bypass bit, and holds them until `conv_done`. On `conv_done` it writes `conv_result` to the result entry with the same index as the command.
- R5: After the conversion of an entry whose pause bit is set, the queue status becomes paused and no further entry runs. The next trigger resumes the queue at the following entry.
- R6: Queue 1 has priority. When both queues are active, every new request comes from queue 1. Queue 2 continues only after queue 1 completes or pauses.
- R7: A queue that converts entry 63 ends there and becomes complete, even without an end-of-queue code. With `q2_start` at 63, queue 2 runs exactly one conversion.
- R8: A trigger that arrives while its queue is active is ignored. It sets that queue's bit in `overrun`, and the bit stays set until reset.
- R9: `rd_data` shows result entry `rd_addr` in the format chosen by `rd_fmt`. Format 0 (and 3) is right-justified: {6'b0, r}. Format 1 is left-justified unsigned: {r, 6'b0}. Format 2 is left-justified signed: {~r[9], r[8:0], 6'b0}.
- R10: After reset, both statuses are idle (0), `overrun` and `conv_req` are 0, and all results read 0. The status codes are 0 idle, 1 active, 2 paused and 3 complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command table write enable |
| cmd_addr | input | 6 | Command table write index |
| cmd_wdata | input | 16 | Command word |
| q1_mode | input | 1 | Queue 1 trigger source (0 software, 1 external) |
| q2_mode | input | 1 | Queue 2 trigger source (0 software, 1 external) |
| sw_go | input | 2 | Software start pulses, bit 0 queue 1, bit 1 queue 2 |
| ext_trig | input | 2 | External trigger levels, bit 0 queue 1, bit 1 queue 2 |
| q2_start | input | 6 | First entry of queue 2 |
| conv_req | output | 1 | Conversion request strobe |
| conv_chan | output | 6 | Channel for the conversion |
| conv_ist | output | 2 | Sample-time code for the conversion |
| conv_byp | output | 1 | Bypass option for the conversion |
| conv_done | input | 1 | Conversion complete strobe |
| conv_result | input | 10 | Conversion result |
| rd_addr | input | 6 | Result read index |
| rd_fmt | input | 2 | Result read format |
| rd_data | output | 16 | Formatted result |
| q1_status | output | 2 | Queue 1 status |
| q2_status | output | 2 | Queue 2 status |
| overrun | output | 2 | Sticky overrun flags, bit 0 queue 1 |

## Verification
A wrong queue pointer shows up at the converter port on the very next request, as a channel that differs from the expected order. It also shows up later as a result stored at the wrong read index. A wrong status or priority decision shows within a cycle of the trigger or the done strobe, either as a status code or as a request issued on behalf of the wrong queue. The bench logs every request that the converter stub sees and compares the whole order against the programmed tables. This catches pointer, pause and priority faults wherever they first appear.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
    localparam int CHAN_W = 6;
    localparam int IST_W  = 2;
    localparam int RES_W  = 10;
    localparam int WORD_W = 16;
    localparam int CMD_W  = CHAN_W + IST_W + 2;
    localparam int NQ     = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_PAUSED = 2'd2,
        ST_DONE   = 2'd3
    } qstat_e;

    typedef struct packed {
        logic              pause;
        logic              byp;
        logic [IST_W-1:0]  ist;
        logic [CHAN_W-1:0] chan;
    } cmd_t;

    function automatic logic [WORD_W-1:0] fmt_result(input logic [RES_W-1:0] r,
                                                     input logic [1:0] f);
        logic [WORD_W-1:0] o;
        case (f)
            2'd1:    o = {r, {(WORD_W-RES_W){1'b0}}};
            2'd2:    o = {~r[RES_W-1], r[RES_W-2:0], {(WORD_W-RES_W){1'b0}}};
            default: o = {{(WORD_W-RES_W){1'b0}}, r};
        endcase
        return o;
    endfunction
endpackage

// File: rtl/adcq_cmd_store.sv
module adcq_cmd_store
    import adcq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output cmd_t              rcmd_o
);
    logic [DEPTH-1:0][CMD_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[waddr_i] = wdata_i[CMD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rcmd_o = cmd_t'(mem_q[raddr_i]);
endmodule

// File: rtl/adcq_result_store.sv
module adcq_result_store
    import adcq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [RES_W-1:0]  wdata_i,
    input  logic [AW-1:0]     raddr_i,
    input  logic [1:0]        fmt_i,
    output logic [WORD_W-1:0] rdata_o
);
    logic [DEPTH-1:0][RES_W-1:0] res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (we_i) res_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign rdata_o = fmt_result(res_q[raddr_i], fmt_i);
endmodule

// File: rtl/adcq_trig_detect.sv
module adcq_trig_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic sw_go_i,
    input  logic ext_i,
    output logic trig_o
);
    logic ext_d, ext_q;

    always_comb begin
        ext_d  = ext_i;
        trig_o = mode_i ? (ext_i & ~ext_q) : sw_go_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_d;
    end
endmodule

// File: rtl/adcq_seq_ctrl.sv
module adcq_seq_ctrl
    import adcq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NQ-1:0]          trig_i,
    input  logic [NQ-1:0][AW-1:0]  qstart_i,
    output logic [AW-1:0]          cmd_addr_o,
    input  cmd_t                   cmd_i,
    output logic                   conv_req_o,
    output logic [CHAN_W-1:0]      conv_chan_o,
    output logic [IST_W-1:0]       conv_ist_o,
    output logic                   conv_byp_o,
    input  logic                   conv_done_i,
    input  logic [RES_W-1:0]       conv_result_i,
    output logic                   res_we_o,
    output logic [AW-1:0]          res_addr_o,
    output logic [RES_W-1:0]       res_data_o,
    output logic [NQ-1:0][1:0]     stat_o,
    output logic [NQ-1:0]          ovr_o,
    output logic [QW-1:0]          cur_q_o
);
    localparam logic [CHAN_W-1:0] EOQ  = {CHAN_W{1'b1}};
    localparam logic [AW-1:0]     LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [NQ-1:0][1:0]    stat;
        logic [NQ-1:0][AW-1:0] ptr;
        logic [NQ-1:0]         ovr;
        logic                  busy;
        logic [QW-1:0]         cur_q;
        logic [AW-1:0]         cur_idx;
        logic [CHAN_W-1:0]     chan;
        logic [IST_W-1:0]      ist;
        logic                  byp;
        logic                  pause;
        logic                  req;
    } state_t;

    state_t s_d, s_q;
    logic          found;
    logic [QW-1:0] pick;

    always_comb begin
        s_d       = s_q;
        s_d.req   = 1'b0;
        found     = 1'b0;
        pick      = '0;
        for (int q = NQ - 1; q >= 0; q--) begin
            if (s_q.stat[q] == ST_ACTIVE) begin
                found = 1'b1;
                pick  = QW'(q);
            end
        end
        cmd_addr_o = s_q.ptr[pick];
        res_we_o   = 1'b0;
        res_addr_o = s_q.cur_idx;
        res_data_o = conv_result_i;

        if (!s_q.busy) begin
            if (found) begin
                if (cmd_i.chan == EOQ) begin
                    s_d.stat[pick] = ST_DONE;
                end else begin
                    s_d.busy    = 1'b1;
                    s_d.req     = 1'b1;
                    s_d.cur_q   = pick;
                    s_d.cur_idx = s_q.ptr[pick];
                    s_d.chan    = cmd_i.chan;
                    s_d.ist     = cmd_i.ist;
                    s_d.byp     = cmd_i.byp;
                    s_d.pause   = cmd_i.pause;
                end
            end
        end else if (conv_done_i) begin
            s_d.busy = 1'b0;
            res_we_o = 1'b1;
            if (s_q.cur_idx == LAST) begin
                s_d.stat[s_q.cur_q] = ST_DONE;
            end else begin
                s_d.ptr[s_q.cur_q] = s_q.cur_idx + 1'b1;
                if (s_q.pause) s_d.stat[s_q.cur_q] = ST_PAUSED;
            end
        end

        for (int q = 0; q < NQ; q++) begin
            if (trig_i[q]) begin
                if (s_q.stat[q] == ST_ACTIVE) begin
                    s_d.ovr[q] = 1'b1;
                end else begin
                    s_d.stat[q] = ST_ACTIVE;
                    if (s_q.stat[q] != ST_PAUSED) s_d.ptr[q] = qstart_i[q];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign conv_req_o  = s_q.req;
    assign conv_chan_o = s_q.chan;
    assign conv_ist_o  = s_q.ist;
    assign conv_byp_o  = s_q.byp;
    assign stat_o      = s_q.stat;
    assign ovr_o       = s_q.ovr;
    assign cur_q_o     = s_q.cur_q;
endmodule

// File: rtl/adcq_seq.sv
module adcq_seq
    import adcq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    input  logic              q1_mode,
    input  logic              q2_mode,
    input  logic [NQ-1:0]     sw_go,
    input  logic [NQ-1:0]     ext_trig,
    input  logic [AW-1:0]     q2_start,
    output logic              conv_req,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [IST_W-1:0]  conv_ist,
    output logic              conv_byp,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic [AW-1:0]     rd_addr,
    input  logic [1:0]        rd_fmt,
    output logic [WORD_W-1:0] rd_data,
    output logic [1:0]        q1_status,
    output logic [1:0]        q2_status,
    output logic [NQ-1:0]     overrun
);
    logic [NQ-1:0]         mode_v;
    logic [NQ-1:0]         trig_v;
    logic [NQ-1:0][AW-1:0] qstart_v;
    logic [NQ-1:0][1:0]    stat_v;
    logic [AW-1:0]         cmd_raddr;
    cmd_t                  cmd_rd;
    logic                  res_we;
    logic [AW-1:0]         res_addr;
    logic [RES_W-1:0]      res_data;
    logic                  eng_q;

    assign mode_v      = {q2_mode, q1_mode};
    assign qstart_v[0] = '0;
    assign qstart_v[1] = q2_start;
    assign q1_status   = stat_v[0];
    assign q2_status   = stat_v[1];

    for (genvar g = 0; g < NQ; g++) begin : g_trig
        adcq_trig_detect u_trig (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_i  (mode_v[g]),
            .sw_go_i (sw_go[g]),
            .ext_i   (ext_trig[g]),
            .trig_o  (trig_v[g])
        );
    end

    adcq_cmd_store #(.DEPTH(DEPTH)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cmd_we),
        .waddr_i (cmd_addr),
        .wdata_i (cmd_wdata),
        .raddr_i (cmd_raddr),
        .rcmd_o  (cmd_rd)
    );

    adcq_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_i        (trig_v),
        .qstart_i      (qstart_v),
        .cmd_addr_o    (cmd_raddr),
        .cmd_i         (cmd_rd),
        .conv_req_o    (conv_req),
        .conv_chan_o   (conv_chan),
        .conv_ist_o    (conv_ist),
        .conv_byp_o    (conv_byp),
        .conv_done_i   (conv_done),
        .conv_result_i (conv_result),
        .res_we_o      (res_we),
        .res_addr_o    (res_addr),
        .res_data_o    (res_data),
        .stat_o        (stat_v),
        .ovr_o         (overrun),
        .cur_q_o       (eng_q)
    );

    adcq_result_store #(.DEPTH(DEPTH)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (res_we),
        .waddr_i (res_addr),
        .wdata_i (res_data),
        .raddr_i (rd_addr),
        .fmt_i   (rd_fmt),
        .rdata_o (rd_data)
    );
endmodule

// File: rtl/adcq_seq_chk.sv
module adcq_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        conv_req,
    input logic [5:0]  conv_chan,
    input logic [1:0]  q1_status,
    input logic [1:0]  q2_status,
    input logic [1:0]  overrun,
    input logic [1:0]  rd_fmt,
    input logic [15:0] rd_data,
    input logic        eng_q
);
    a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    a_r4_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> $stable(conv_chan));

    a_r4_req_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (q1_status == 2'd1 || q2_status == 2'd1));

    a_r6_q1_first: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && q1_status == 2'd1) |-> (eng_q == 1'b0));

    a_r5_paused_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q1_status != 2'd1 && q2_status != 2'd1) |-> !conv_req);

    a_r8_ovr1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun[0] |=> overrun[0]);

    a_r8_ovr2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun[1] |=> overrun[1]);

    a_r9_left_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fmt == 2'd1 || rd_fmt == 2'd2) |-> (rd_data[5:0] == 6'd0));
endmodule

bind adcq_seq adcq_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_req  (conv_req),
    .conv_chan (conv_chan),
    .q1_status (q1_status),
    .q2_status (q2_status),
    .overrun   (overrun),
    .rd_fmt    (rd_fmt),
    .rd_data   (rd_data),
    .eng_q     (eng_q)
);

// File: tb/tb_adcq_seq.sv
module tb_adcq_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [5:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        q1_mode = 1'b0;
    logic        q2_mode = 1'b0;
    logic [1:0]  sw_go = '0;
    logic [1:0]  ext_trig = '0;
    logic [5:0]  q2_start = '0;
    logic        conv_req;
    logic [5:0]  conv_chan;
    logic [1:0]  conv_ist;
    logic        conv_byp;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_result = '0;
    logic [5:0]  rd_addr = '0;
    logic [1:0]  rd_fmt = '0;
    logic [15:0] rd_data;
    logic [1:0]  q1_status;
    logic [1:0]  q2_status;
    logic [1:0]  overrun;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adcq_seq dut (.*);

    // vector table: {channel[5:0], read format[1:0]} for entries 0..7
    localparam logic [7:0] VEC [8] = '{
        {6'd0,  2'd0}, {6'd62, 2'd1}, {6'd17, 2'd2}, {6'd40, 2'd3},
        {6'd33, 2'd2}, {6'd9,  2'd1}, {6'd50, 2'd0}, {6'd1,  2'd2}
    };

    function automatic logic [9:0] res_of(input logic [5:0] ch);
        return 10'((int'(ch) * 13 + 7) % 1024);
    endfunction

    function automatic logic [15:0] fmt_ref(input logic [9:0] r, input logic [1:0] f);
        case (f)
            2'd1:    return {r, 6'b0};
            2'd2:    return {~r[9], r[8:0], 6'b0};
            default: return {6'b0, r};
        endcase
    endfunction

    // converter stub and request log
    logic [5:0] log_ch  [128];
    logic [1:0] log_ist [128];
    logic       log_byp [128];
    int log_n = 0;
    int pend_cnt = 0;
    logic [5:0] pend_ch = '0;

    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_req) begin
            log_ch[log_n]  <= conv_chan;
            log_ist[log_n] <= conv_ist;
            log_byp[log_n] <= conv_byp;
            log_n    <= log_n + 1;
            pend_ch  <= conv_chan;
            pend_cnt <= 2;
        end else if (pend_cnt > 0) begin
            pend_cnt <= pend_cnt - 1;
            if (pend_cnt == 1) begin
                conv_done   <= 1'b1;
                conv_result <= res_of(pend_ch);
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put_cmd(input int addr, input bit pause, input bit byp,
                           input logic [1:0] ist, input logic [5:0] ch);
        @(negedge clk);
        cmd_we    = 1'b1;
        cmd_addr  = 6'(addr);
        cmd_wdata = {6'b101010, pause, byp, ist, ch};
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic sw_pulse(input int q);
        @(negedge clk);
        sw_go[q] = 1'b1;
        @(negedge clk);
        sw_go[q] = 1'b0;
    endtask

    task automatic ext_edge(input int q);
        @(negedge clk);
        ext_trig[q] = 1'b0;
        @(negedge clk);
        ext_trig[q] = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_stat(input int q, input logic [1:0] v);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if ((q == 0 ? q1_status : q2_status) == v) break;
        end
    endtask

    task automatic read_res(input int addr, input logic [1:0] f, output logic [15:0] d);
        @(negedge clk);
        rd_addr = 6'(addr);
        rd_fmt  = f;
        #1;
        d = rd_data;
    endtask

    initial begin
        int base;
        logic [15:0] d;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "q1_status", int'(q1_status), 0);
        chk("R10", "q2_status", int'(q2_status), 0);
        chk("R10", "overrun", int'(overrun), 0);
        chk("R10", "conv_req", int'(conv_req), 0);
        chk("R10", "rd_data", int'(rd_data), 0);
        rst_n = 1'b1;

        // vector walk: queue 1 over entries 0..7, end code at 8 (R1 R3 R4 R9)
        for (int i = 0; i < 8; i++)
            put_cmd(i, 1'b0, VEC[i][2], VEC[i][1:0] ^ 2'(i), VEC[i][7:2]);
        put_cmd(8, 1'b0, 1'b0, 2'd0, 6'd63);
        base = log_n;
        sw_pulse(0);
        wait_stat(0, 2'd3);
        chk("R3", "q1 complete", int'(q1_status), 3);
        chk("R3", "q1 conversions", log_n - base, 8);
        for (int i = 0; i < 8; i++) begin
            chk("R4", "channel order", int'(log_ch[base + i]), int'(VEC[i][7:2]));
            chk("R1", "sample time", int'(log_ist[base + i]), int'(VEC[i][1:0] ^ 2'(i)));
            chk("R1", "bypass", int'(log_byp[base + i]), int'(VEC[i][2]));
            read_res(i, VEC[i][1:0], d);
            chk("R9", "formatted result", int'(d), int'(fmt_ref(res_of(VEC[i][7:2]), VEC[i][1:0])));
        end

        // R2: queue 2 external mode ignores software pulse; R5 pause
        put_cmd(20, 1'b1, 1'b0, 2'd1, 6'd5);
        put_cmd(21, 1'b0, 1'b1, 2'd2, 6'd6);
        put_cmd(22, 1'b0, 1'b0, 2'd0, 6'd63);
        q2_start = 6'd20;
        q2_mode  = 1'b1;
        base = log_n;
        sw_pulse(1);
        repeat (5) @(negedge clk);
        chk("R2", "q2 idle after ignored sw pulse", int'(q2_status), 0);
        chk("R2", "no request from ignored pulse", log_n - base, 0);
        ext_edge(1);
        wait_stat(1, 2'd2);
        chk("R5", "q2 paused", int'(q2_status), 2);
        chk("R5", "one conversion before pause", log_n - base, 1);
        chk("R3", "q2 first channel", int'(log_ch[base]), 5);
        read_res(20, 2'd1, d);
        chk("R4", "result at entry 20", int'(d), int'(fmt_ref(res_of(6'd5), 2'd1)));
        ext_edge(1);
        wait_stat(1, 2'd3);
        chk("R5", "resume at next entry", int'(log_ch[base + 1]), 6);
        chk("R5", "q2 complete after resume", int'(q2_status), 3);

        // R6 priority: trigger both in the same cycle
        base = log_n;
        @(negedge clk);
        ext_trig[1] = 1'b0;
        @(negedge clk);
        sw_go[0] = 1'b1;
        ext_trig[1] = 1'b1;
        @(negedge clk);
        sw_go[0] = 1'b0;
        wait_stat(1, 2'd2);
        chk("R6", "q1 complete first", int'(q1_status), 3);
        for (int i = 0; i < 8; i++)
            chk("R6", "q1 served first", int'(log_ch[base + i]), int'(VEC[i][7:2]));
        chk("R6", "q2 after q1", int'(log_ch[base + 8]), 5);

        // R8 overrun
        chk("R8", "no overrun yet", int'(overrun), 0);
        base = log_n;
        sw_pulse(0);
        repeat (3) @(negedge clk);
        sw_pulse(0);
        @(negedge clk);
        chk("R8", "overrun q1 set", int'(overrun), 1);
        wait_stat(0, 2'd3);
        chk("R8", "ignored trigger did not restart", log_n - base, 8);
        chk("R8", "overrun sticky", int'(overrun), 1);

        // finish q2 (paused at 21), then R7 start at last entry
        ext_edge(1);
        wait_stat(1, 2'd3);
        put_cmd(63, 1'b0, 1'b0, 2'd3, 6'd9);
        q2_start = 6'd63;
        base = log_n;
        ext_edge(1);
        wait_stat(1, 2'd3);
        repeat (3) @(negedge clk);
        chk("R7", "single conversion at last entry", log_n - base, 1);
        chk("R7", "channel at last entry", int'(log_ch[base]), 9);
        chk("R7", "q2 complete", int'(q2_status), 3);
        read_res(63, 2'd0, d);
        chk("R7", "result at entry 63", int'(d), int'(res_of(6'd9)));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule